// File: doc/BRIEF.md
# Single/half precision to 8-bit float converter

This block turns a 32-bit single-precision value, or a 16-bit half-precision value picked by a format input, into an 8-bit float. The 8-bit format has one sign bit, four exponent bits with a bias of 8, and three mantissa bits. It has no infinities, and its only NaN is the code that would otherwise be negative zero. Values beyond the format's range saturate to the largest magnitude. Two rounding modes are offered: round to nearest with ties to even, and stochastic rounding, in which a caller-supplied random word is added to the discarded bits before truncation.

Samples enter through a valid/ready handshake. A two-stage pipeline then produces the result. The first stage aligns the mantissa and exponent to the 8-bit range. The second stage rounds, handles carries and saturates, then writes the output register. Both stages advance together whenever the output register is empty or is being taken, so with a continuously ready sink the block accepts one value per cycle.

Top module: `fp8_e4m3_conv`

## Requirements
- R1: The result carries the sign in bit 7, the biased exponent (bias 8) in bits 6:3 and the mantissa in bits 2:0; 1.0 maps to 0x40.
- R2: An input whose exponent field is all ones (infinity or NaN, either sign) yields 0x80.
- R3: A zero input of either sign, and any value that rounds to zero, yields 0x00; 0x80 is never produced from a finite input.
- R4: With `in_half`=1 the converter reads a half-precision value (bias 15, 10-bit mantissa) from `in_data[15:0]` and ignores `in_data[31:16]`; with `in_half`=0 it reads a single-precision value (bias 127, 23-bit mantissa) from all 32 bits.
- R5: In nearest mode (`in_stoch`=0) the result is the nearest representable value, and an exact tie goes to the code with an even mantissa LSB. Input bits shifted out during alignment still count in the tie decision.
- R6: Magnitudes below 2^-7 are encoded with exponent field 0 and a step of 2^-10. A rounding carry out of that range gives exponent field 1 with mantissa 0.
- R7: A magnitude that after rounding would exceed 240 yields sign|0x7F.
- R8: With `in_stoch`=1, the low discarded bits of `in_rand` (bits 6:0 in half mode, bits 19:0 in single mode) are added to the aligned mantissa, and the result is then truncated. Higher bits of `in_rand` have no effect. A zero random word truncates toward zero, and an all-ones word rounds any inexact normal-range value up.
- R9: A value accepted at one rising edge appears with `out_valid` high after the second following edge. With `out_ready` held high, `in_ready` never drops, and the block converts one value per cycle.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold, and `in_ready` is low once both stages are occupied. Results leave in acceptance order.
- R11: A low `rst_n`, sampled at a rising edge, empties both stages, so `out_valid` reads low after reset and stays low until a new value has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source word is present |
| in_ready | output | 1 | Block takes the source word at this edge |
| in_data | input | 32 | Source word (half-precision in bits 15:0 when `in_half`=1) |
| in_half | input | 1 | 1 = half-precision source, 0 = single-precision |
| in_stoch | input | 1 | 1 = stochastic rounding, 0 = nearest, ties to even |
| in_rand | input | 23 | Random bits added below the kept mantissa in stochastic mode |
| out_valid | output | 1 | Result register holds a value |
| out_ready | input | 1 | Sink takes the result at this edge |
| out_data | output | 8 | 8-bit float result |

## Verification
A wrong tie or alignment decision inside the first stage shows up as an off-by-one-code result, two edges after the offending value was accepted. Such an error only appears at exact midpoints or in the subnormal band, so the half-precision space is swept completely and the single-precision exponents around the 8-bit range are swept with and without sticky bits. A broken stall or advance path shows up as a lost, repeated or reordered result, or as a change of `out_data` while the sink is not ready. It becomes visible in the first cycle that backpressure is applied.

// File: rtl/fp8_e4m3_conv.sv
module fp8_e4m3_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_half,
  input  logic        in_stoch,
  input  logic [22:0] in_rand,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data
);

  // ---------------- stage 1: decode and align ----------------
  logic [7:0]        e_raw;
  logic [22:0]       m_raw;
  logic              sgn, is_special, is_norm;
  logic [4:0]        mfmt;
  logic signed [9:0] bias, act, dsg, f8e;
  logic [5:0]        shamt;
  logic [6:0]        nbits;
  logic [24:0]       m_full, m_sh;
  logic              mid;

  assign e_raw      = in_half ? {3'b000, in_data[14:10]} : in_data[30:23];
  assign m_raw      = in_half ? {13'd0, in_data[9:0]} : in_data[22:0];
  assign sgn        = in_half ? in_data[15] : in_data[31];
  assign is_special = in_half ? (in_data[14:10] == 5'h1F) : (in_data[30:23] == 8'hFF);
  assign is_norm    = (e_raw != 8'd0);
  assign mfmt       = in_half ? 5'd10 : 5'd23;
  assign bias       = in_half ? 10'sd15 : 10'sd127;
  assign act        = is_norm ? ($signed({2'b00, e_raw}) - bias) : (10'sd1 - bias);
  assign dsg        = -10'sd7 - act;
  assign shamt      = (act > -10'sd7) ? 6'd0 : ((dsg > 10'sd40) ? 6'd40 : dsg[5:0]);
  assign nbits      = {2'b00, mfmt} - 7'd3 + {1'b0, shamt};
  assign m_full     = is_norm ? ({2'b00, m_raw} | (25'd1 << mfmt)) : {2'b00, m_raw};
  assign mid        = (nbits <= 7'd24) &&
                      ((m_full & ((25'd1 << nbits) - 25'd1)) == (25'd1 << (nbits - 7'd1)));
  assign m_sh       = m_full >> shamt;
  assign f8e        = (act > -10'sd7) ? (act + 10'sd8) : (m_sh[mfmt] ? 10'sd1 : 10'sd0);

  logic              s1_valid, s1_sign, s1_special, s1_half, s1_mid, s1_stoch;
  logic [24:0]       s1_m;
  logic signed [9:0] s1_e;
  logic [22:0]       s1_rnd;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
    end else if (in_ready) begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      s1_sign    <= sgn;
      s1_special <= is_special;
      s1_half    <= in_half;
      s1_mid     <= mid;
      s1_stoch   <= in_stoch;
      s1_m       <= m_sh;
      s1_e       <= f8e;
      s1_rnd     <= in_rand;
    end
  end

  // ---------------- stage 2: round, carry, saturate ----------------
  logic [4:0]        sh, mf2;
  logic [25:0]       drop, base, add, m2, m3;
  logic              odd;
  logic signed [9:0] e2;
  logic [2:0]        mk3;
  logic [7:0]        result;

  assign sh   = s1_half ? 5'd7 : 5'd20;
  assign mf2  = s1_half ? 5'd10 : 5'd23;
  assign drop = (26'd1 << sh) - 26'd1;
  assign odd  = s1_m[sh];
  assign base = {1'b0, s1_m};
  assign add  = s1_stoch ? ({3'b000, s1_rnd} & drop)
                         : ((s1_mid ? (odd ? base : base - 26'd1) : base) & drop);
  assign m2   = base + add;

  always_comb begin
    e2 = s1_e;
    m3 = m2;
    if (s1_e == 10'sd0) begin
      if (m2[mf2]) e2 = 10'sd1;
    end else if (m2[mf2 + 5'd1]) begin
      m3 = m2 >> 1;
      e2 = s1_e + 10'sd1;
    end
  end

  assign mk3 = 3'(m3 >> sh);

  always_comb begin
    if (s1_special)                        result = 8'h80;
    else if (e2 > 10'sd15)                 result = {s1_sign, 7'h7F};
    else if (e2 == 10'sd0 && mk3 == 3'd0)  result = 8'h00;
    else                                   result = {s1_sign, e2[3:0], mk3};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && s1_valid) out_data <= result;
  end

endmodule

// File: rtl/fp8_e4m3_conv_chk.sv
module fp8_e4m3_conv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       s1_valid,
  input logic       s1_special
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_s1_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !in_ready |=> s1_valid);

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);

  assert_rise_from_s1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid));

  assert_nan_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && s1_special && in_ready |=> out_valid && out_data == 8'h80);

  assert_no_neg_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(in_ready) && $past(s1_valid) && out_data == 8'h80 |-> $past(s1_special));

endmodule

bind fp8_e4m3_conv fp8_e4m3_conv_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .s1_valid   (s1_valid),
  .s1_special (s1_special)
);

// File: tb/fp8_e4m3_conv_tb.sv
`timescale 1ns/1ps
module fp8_e4m3_conv_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_half = 1'b0;
  logic        in_stoch = 1'b0;
  logic [22:0] in_rand = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int blocked = 0;
  int ready_mode = 0;

  logic [7:0]  exp_q[$];
  logic [31:0] in_q[$];
  string       tag_q[$];

  fp8_e4m3_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_half(in_half), .in_stoch(in_stoch), .in_rand(in_rand),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic real p2(input int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else        for (int i = 0; i < -k; i++) r = r * 0.5;
    return r;
  endfunction

  function automatic int lg2(input real a);
    int k = -7;
    while (k < 8 && a >= p2(k + 1)) k++;
    return k;
  endfunction

  // rmode: 0 nearest-even, 1 truncate, 2 round up when inexact
  function automatic logic [7:0] ref_code(input logic [31:0] w, input bit hf, input int rmode);
    int e, m, fl, k;
    bit s;
    real a, q, n, fr, r;
    if (hf) begin
      s = w[15]; e = int'(w[14:10]); m = int'(w[9:0]);
      if (e == 31) return 8'h80;
      a = (e == 0) ? real'(m) * p2(-24) : (1024.0 + real'(m)) * p2(e - 25);
    end else begin
      s = w[31]; e = int'(w[30:23]); m = int'(w[22:0]);
      if (e == 255) return 8'h80;
      a = (e == 0) ? real'(m) * p2(-149) : (8388608.0 + real'(m)) * p2(e - 150);
    end
    if (a >= 240.0) return {s, 7'h7F};
    q  = (a < p2(-7)) ? p2(-10) : p2(lg2(a) - 3);
    n  = a / q;
    fl = $rtoi($floor(n));
    fr = n - real'(fl);
    if (rmode == 0) begin
      if (fr > 0.5 || (fr == 0.5 && (fl % 2) == 1)) fl++;
    end else if (rmode == 2) begin
      if (fr > 0.0) fl++;
    end
    r = real'(fl) * q;
    if (r > 240.0) r = 240.0;
    if (r == 0.0) return 8'h00;
    if (r < p2(-7)) return {s, 4'h0, 3'($rtoi(r / p2(-10)))};
    k = lg2(r);
    return {s, 4'(k + 8), 3'($rtoi(r / p2(k) * 8.0) - 8)};
  endfunction

  function automatic string cat_of(input logic [7:0] c, input int rmode);
    if (rmode != 0)              return "R8";
    if (c == 8'h80)              return "R2";
    if (c[6:0] == 7'h00)         return "R3";
    if (c[6:0] == 7'h7F)         return "R7";
    if (c[6:3] == 4'h0)          return "R6";
    return "R1";
  endfunction

  task automatic check8(input logic [7:0] got, input logic [7:0] exp, input string tag,
                        input logic [31:0] src);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s in=%08h actual=%02h expected=%02h", tag, src, got, exp);
    end
  endtask

  task automatic check1(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic set_ready();
    if (ready_mode == 0)      out_ready = 1'b1;
    else if (ready_mode == 1) out_ready = (cyc % 3) != 0;
    else                      out_ready = 1'b0;
  endtask

  task automatic monitor();
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 unexpected result actual=%02h expected=none", out_data);
      end else begin
        check8(out_data, exp_q.pop_front(), tag_q.pop_front(), in_q.pop_front());
      end
    end
  endtask

  task automatic send(input logic [31:0] w, input bit hf, input bit st, input logic [22:0] rn,
                      input logic [7:0] e, input string tag);
    bit acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      set_ready();
      in_valid = 1'b1; in_data = w; in_half = hf; in_stoch = st; in_rand = rn;
      #1;
      monitor();
      acc = in_ready;
      if (!acc) blocked++;
      @(posedge clk);
    end
    exp_q.push_back(e); in_q.push_back(w); tag_q.push_back(tag);
  endtask

  task automatic sendr(input logic [31:0] w, input bit hf, input int rmode, input string base);
    logic [7:0] e;
    e = ref_code(w, hf, rmode);
    send(w, hf, rmode != 0, (rmode == 2) ? 23'h7FFFFF : 23'h0, e, {base, " ", cat_of(e, rmode)});
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk);
      in_valid = 1'b0;
      set_ready();
      #1;
      monitor();
      @(posedge clk);
      guard++;
    end
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R10 results missing actual=%0d expected=0", exp_q.size());
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    int blocked_before;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check1(out_valid, 1'b0, "R11 out_valid in reset");
    check1(in_ready, 1'b1, "R11 ready in reset");
    rst_n = 1'b1;

    // R9 latency: accept at P1, visible after P2
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_data = 32'h3F800000; in_half = 1'b0;
    in_stoch = 1'b0; in_rand = '0;
    #1 check1(in_ready, 1'b1, "R9 ready when empty");
    @(negedge clk);
    in_valid = 1'b0;
    check1(out_valid, 1'b0, "R9 not yet valid after one edge");
    @(negedge clk);
    check1(out_valid, 1'b1, "R9 valid after two edges");
    check8(out_data, 8'h40, "R9 R1 one", 32'h3F800000);
    @(negedge clk);
    check1(out_valid, 1'b0, "R9 emptied after take");

    // directed corner values
    send(32'h3F800000, 0, 0, 0, 8'h40, "R1 single 1.0");
    send(32'hA5A53C00, 1, 0, 0, 8'h40, "R4 half 1.0 upper bits ignored");
    send(32'hC3700000, 0, 0, 0, 8'hFF, "R7 minus 240");
    send(32'h43960000, 0, 0, 0, 8'h7F, "R7 300 saturates");
    send(32'h7F800000, 0, 0, 0, 8'h80, "R2 +inf");
    send(32'hFF800000, 0, 0, 0, 8'h80, "R2 -inf");
    send(32'h7FC00001, 0, 0, 0, 8'h80, "R2 nan");
    send(32'h0000FC00, 1, 0, 0, 8'h80, "R2 R4 half -inf");
    send(32'h80000000, 0, 0, 0, 8'h00, "R3 minus zero");
    send(32'h00008001, 1, 0, 0, 8'h00, "R3 tiny negative");
    send(32'h00003C40, 1, 0, 0, 8'h40, "R5 tie down to even");
    send(32'h00003CC0, 1, 0, 0, 8'h42, "R5 tie up to even");
    send(32'h3F880001, 0, 0, 0, 8'h41, "R5 sticky breaks tie");
    send(32'h3A800000, 0, 0, 0, 8'h01, "R6 smallest subnormal");
    send(32'h3B800000, 0, 0, 0, 8'h04, "R6 subnormal 2^-8");
    send(32'h3BF00000, 0, 0, 0, 8'h08, "R6 carry promotes exponent");
    send(32'h3F880000, 0, 1, 23'h000000, 8'h40, "R8 zero rand truncates");
    send(32'h3F880000, 0, 1, 23'h080000, 8'h41, "R8 rand adds below LSB");
    send(32'h00003C40, 1, 1, 23'h7FFF80, 8'h40, "R8 upper rand bits ignored in half");
    drain();

    // exhaustive half precision, nearest-even
    for (int i = 0; i < 65536; i++) sendr({16'hA5A5, 16'(i)}, 1, 0, "R4 R5");
    // stochastic truncation sweep
    for (int i = 0; i < 65536; i += 4) sendr({16'h5A5A, 16'(i)}, 1, 1, "R8 trunc");
    // stochastic round-up sweep, normal range only
    for (int i = 1; i < 65536; i += 4) begin
      logic [15:0] h;
      h = 16'(i);
      if (h[14:10] >= 5'd8 && h[14:10] != 5'h1F) sendr({16'h0, h}, 1, 2, "R8 up");
    end
    // single precision around the 8-bit range, with and without sticky bit
    for (int s = 0; s < 2; s++)
      for (int e = 110; e <= 140; e++)
        for (int i = 0; i < 64; i++)
          for (int j = 0; j < 2; j++)
            sendr({1'(s), 8'(e), 6'(i), 16'd0, 1'(j)}, 0, 0, "R4 R5 single");
    sendr(32'h00000001, 0, 0, "R3 single subnormal");
    drain();
    check1(blocked == 0, 1'b1, "R9 no stall with ready sink");

    // backpressure with an irregular sink
    blocked_before = blocked;
    ready_mode = 1;
    for (int i = 0; i < 600; i++) sendr({16'h0, 16'((i * 97 + 13) % 65536)}, 1, 0, "R10 stalled");
    drain();
    check1(blocked > blocked_before, 1'b1, "R10 ready drops under stall");
    ready_mode = 0;

    // hold while sink not ready
    ready_mode = 2;
    send(32'h00003C00, 1, 0, 0, 8'h40, "R10 first");
    send(32'h0000BC00, 1, 0, 0, 8'hC0, "R10 second");
    @(negedge clk);
    in_valid = 1'b0;
    set_ready();
    #1;
    check1(in_ready, 1'b0, "R10 ready low when full");
    check1(out_valid, 1'b1, "R10 valid held");
    check8(out_data, 8'h40, "R10 oldest first", 32'h00003C00);
    held = out_data;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check8(out_data, held, "R10 data stable", 32'h00003C00);
    end

    // reset with both stages full
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check1(out_valid, 1'b0, "R11 reset clears output");
    rst_n = 1'b1;
    exp_q.delete(); in_q.delete(); tag_q.delete();
    ready_mode = 0;
    out_ready = 1'b1;
    @(negedge clk);
    check1(out_valid, 1'b0, "R11 first stage cleared");
    @(negedge clk);
    check1(out_valid, 1'b0, "R11 stays empty");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule